// File: doc/BRIEF.md
# Frame Line Scan Address Generator

This block produces the display-line address that a panel refresh engine uses to fetch one row of display memory per line period. A start line, written through a one-cycle command strobe, sets which memory line is shown on the first common row of the panel. A frame-sync pulse copies the start line into a running line counter. Each line-clock pulse then moves the counter on by one, so rewriting the start line scrolls the picture vertically. The counter wraps from the top line back to line 0.

A second counter tracks how many line slots have passed since the last sync. When the extra-line mode is on, the last slot of the frame does not show a memory line. Instead the block outputs a fixed indicator address. That slot is slot 33 for the short duty setting and slot 65 for the long one, and the line counter keeps stepping underneath it. Sync, line clock and command write are all synchronous enables sampled on the rising edge of the single block clock.

Top module: `line_scan_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `line_addr` is 0 and `ind_sel` is 0.
- R2: A write on `cmd_we` does not change `line_addr` in the current frame. The written value is used only at the next `frame_sync`.
- R3: One cycle after a `frame_sync` pulse, `line_addr[5:0]` equals the start line held before that edge and `line_addr[6]` is 0.
- R4: Each `line_clk` pulse without sync advances the line counter by one, so the next slot shows the previous line plus one.
- R5: The line counter wraps modulo 64, so line 63 is followed by line 0.
- R6: With `plus_one_en`=1 and `duty_long`=1, slot index 64 after sync (the 65th slot) outputs `line_addr`=64 (bit 6 set, bits 5:0 zero) with `ind_sel`=1.
- R7: With `plus_one_en`=1 and `duty_long`=0, slot index 32 (the 33rd slot) outputs `line_addr`=64 with `ind_sel`=1.
- R8: With `plus_one_en`=0, `ind_sel` stays 0 and `line_addr[6]` stays 0 in every slot.
- R9: When `frame_sync` and `line_clk` are both high in one cycle, sync wins. The counter loads the start line and the slot count goes back to 0.
- R10: In any slot other than the indicator slot, `line_addr` equals (start line + slot index) mod 64, including slots after the indicator slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Start-line write strobe |
| cmd_line | input | 6 | Start line value to write |
| frame_sync | input | 1 | Frame start pulse |
| line_clk | input | 1 | Line step pulse |
| duty_long | input | 1 | 1 selects the 65-slot frame, 0 the 33-slot frame |
| plus_one_en | input | 1 | Enables the indicator slot at the end of the frame |
| line_addr | output | 7 | Line address; 64 denotes the indicator line |
| ind_sel | output | 1 | High during the indicator slot |

## Verification
With the default combinational output stage, every result shows up in the cycle right after the edge that samples the stimulus. A sync, step or write driven before edge n is reflected in `line_addr` and `ind_sel` after edge n. The bench drives inputs on the falling edge and keeps a reference model that it updates by one edge per drive. At each falling edge it compares the outputs with the model before it drives the next stimulus. A start-line write takes effect only after the following sync edge, and the bench's expected value waits for that edge.

// File: rtl/lscan_pkg.sv
package lscan_pkg;
   typedef enum logic {
      DUTY_SHORT = 1'b0,
      DUTY_LONG  = 1'b1
   } duty_e;

   typedef struct packed {
      logic load;
      logic step;
   } ctr_cmd_t;

   function automatic ctr_cmd_t decode_ctl(input logic sync_i, input logic lclk_i);
      ctr_cmd_t c;
      c.load = sync_i;
      c.step = lclk_i & ~sync_i;
      return c;
   endfunction
endpackage

// File: rtl/lscan_start_reg.sv
module lscan_start_reg #(
   parameter int LINE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LINE_W-1:0] din,
   output logic [LINE_W-1:0] q
);
   initial begin
      if (LINE_W < 1) $error("lscan_start_reg: LINE_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= din;
   end
endmodule

// File: rtl/lscan_line_ctr.sv
module lscan_line_ctr #(
   parameter int LINE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LINE_W-1:0] load_val,
   input  logic              step,
   output logic [LINE_W-1:0] q
);
   localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (step)  q <= q + ONE;
   end
endmodule

// File: rtl/lscan_slot_ctr.sv
module lscan_slot_ctr #(
   parameter int SLOT_W  = 7,
   parameter int DUTY_LO = 33,
   parameter int DUTY_HI = 65
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  lscan_pkg::duty_e  duty,
   output logic              last,
   output logic [SLOT_W-1:0] slot_q
);
   localparam logic [SLOT_W-1:0] LAST_LO = SLOT_W'(DUTY_LO - 1);
   localparam logic [SLOT_W-1:0] LAST_HI = SLOT_W'(DUTY_HI - 1);
   localparam logic [SLOT_W-1:0] SAT     = {SLOT_W{1'b1}};

   initial begin
      if (DUTY_HI - 1 > int'(SAT)) $error("lscan_slot_ctr: SLOT_W too narrow");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     slot_q <= '0;
      else if (clear)                 slot_q <= '0;
      else if (step && slot_q != SAT) slot_q <= slot_q + SLOT_W'(1);
   end

   always_comb begin
      unique case (duty)
         lscan_pkg::DUTY_LONG:  last = (slot_q == LAST_HI);
         default:               last = (slot_q == LAST_LO);
      endcase
   end
endmodule

// File: rtl/lscan_addr_sel.sv
module lscan_addr_sel #(
   parameter int LINE_W  = 6,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] cnt,
   input  logic              last_slot,
   input  logic              en,
   output logic [LINE_W:0]   addr,
   output logic              ind
);
   localparam logic [LINE_W:0] IND_ADDR = {1'b1, {LINE_W{1'b0}}};

   logic          ind_c;
   logic [LINE_W:0] addr_c;

   always_comb begin
      ind_c  = en & last_slot;
      addr_c = ind_c ? IND_ADDR : {1'b0, cnt};
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr <= '0;
               ind  <= 1'b0;
            end else begin
               addr <= addr_c;
               ind  <= ind_c;
            end
         end
      end else begin : g_comb
         assign addr = addr_c;
         assign ind  = ind_c;
      end
   endgenerate
endmodule

// File: rtl/line_scan_gen.sv
module line_scan_gen #(
   parameter int LINE_W  = 6,
   parameter int DUTY_LO = 33,
   parameter int DUTY_HI = 65,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [LINE_W-1:0] cmd_line,
   input  logic              frame_sync,
   input  logic              line_clk,
   input  logic              duty_long,
   input  logic              plus_one_en,
   output logic [LINE_W:0]   line_addr,
   output logic              ind_sel
);
   localparam int SLOT_W = $clog2(DUTY_HI + 1);

   initial begin
      if (DUTY_LO < 2)                $error("line_scan_gen: DUTY_LO too small");
      if (DUTY_HI <= DUTY_LO)         $error("line_scan_gen: DUTY_HI must exceed DUTY_LO");
      if (DUTY_HI > (1 << LINE_W) + 1) $error("line_scan_gen: DUTY_HI exceeds line space");
   end

   lscan_pkg::ctr_cmd_t ctl;
   logic [LINE_W-1:0]   start_q;
   logic [LINE_W-1:0]   cnt_q;
   logic [SLOT_W-1:0]   slot_q;
   logic                last_slot;
   lscan_pkg::duty_e    duty;

   always_comb begin
      ctl  = lscan_pkg::decode_ctl(frame_sync, line_clk);
      duty = duty_long ? lscan_pkg::DUTY_LONG : lscan_pkg::DUTY_SHORT;
   end

   lscan_start_reg #(.LINE_W(LINE_W)) u_start (
      .clk(clk), .rst_n(rst_n), .we(cmd_we), .din(cmd_line), .q(start_q)
   );

   lscan_line_ctr #(.LINE_W(LINE_W)) u_line (
      .clk(clk), .rst_n(rst_n), .load(ctl.load), .load_val(start_q),
      .step(ctl.step), .q(cnt_q)
   );

   lscan_slot_ctr #(.SLOT_W(SLOT_W), .DUTY_LO(DUTY_LO), .DUTY_HI(DUTY_HI)) u_slot (
      .clk(clk), .rst_n(rst_n), .clear(ctl.load), .step(ctl.step),
      .duty(duty), .last(last_slot), .slot_q(slot_q)
   );

   lscan_addr_sel #(.LINE_W(LINE_W), .OUT_REG(OUT_REG)) u_sel (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .last_slot(last_slot),
      .en(plus_one_en), .addr(line_addr), .ind(ind_sel)
   );
endmodule

// File: rtl/lscan_checker.sv
module lscan_checker #(
   parameter int LINE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_we,
   input logic              frame_sync,
   input logic              line_clk,
   input logic              plus_one_en,
   input logic [LINE_W:0]   line_addr,
   input logic              ind_sel,
   input logic [LINE_W-1:0] start_q,
   input logic [LINE_W-1:0] cnt_q
);
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (line_addr == '0 && !ind_sel)); // R1
   AST_WRITE_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !frame_sync && !line_clk) |=> $stable(cnt_q)); // R2
   AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> (cnt_q == $past(start_q))); // R3
   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (line_clk && !frame_sync) |=> (cnt_q == $past(cnt_q) + LINE_W'(1))); // R5
   AST_NO_IND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !plus_one_en |-> (!ind_sel && !line_addr[LINE_W])); // R8
   AST_IND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ind_sel |-> (line_addr == {1'b1, {LINE_W{1'b0}}})); // R6
endmodule

bind line_scan_gen lscan_checker #(.LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .frame_sync(frame_sync),
   .line_clk(line_clk), .plus_one_en(plus_one_en), .line_addr(line_addr),
   .ind_sel(ind_sel), .start_q(start_q), .cnt_q(cnt_q)
);

// File: tb/sim_line_scan_gen.sv
`timescale 1ns/1ps
module sim_line_scan_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_we = 1'b0, frame_sync = 1'b0, line_clk = 1'b0;
   logic       duty_long = 1'b0, plus_one_en = 1'b0;
   logic [5:0] cmd_line = '0;
   logic [6:0] line_addr;
   logic       ind_sel;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   string tag = "R1";

   int m_start = 0, m_cnt = 0, m_slot = 0;

   always #2 clk = ~clk;

   line_scan_gen u0 (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_line(cmd_line),
      .frame_sync(frame_sync), .line_clk(line_clk), .duty_long(duty_long),
      .plus_one_en(plus_one_en), .line_addr(line_addr), .ind_sel(ind_sel)
   );

   function automatic bit exp_ind();
      int last = duty_long ? 64 : 32;
      return plus_one_en && (m_slot == last);
   endfunction

   function automatic int exp_addr();
      return exp_ind() ? 64 : m_cnt;
   endfunction

   task automatic check();
      n_chk++;
      if (line_addr !== 7'(exp_addr()) || ind_sel !== exp_ind()) begin
         n_err++;
         $display("FAIL %s: addr=%0d ind=%0b expected addr=%0d ind=%0b",
                  tag, line_addr, ind_sel, exp_addr(), exp_ind());
      end
   endtask

   // check the current outputs, then drive one cycle and advance the model
   task automatic tick(input bit we, input int val, input bit sy, input bit lc);
      @(negedge clk);
      check();
      cmd_we = we; cmd_line = 6'(val); frame_sync = sy; line_clk = lc;
      if (sy) begin
         m_cnt = m_start; m_slot = 0;
      end else if (lc) begin
         m_cnt = (m_cnt + 1) % 64;
         if (m_slot != 127) m_slot++;
      end
      if (we) m_start = val;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      tag = "R1"; check();
      @(negedge clk); rst_n = 1'b1;
      tick(0, 0, 0, 0);
      // R2: write without sync, step lines, address ignores the new start
      tag = "R2";
      tick(1, 10, 0, 0);
      tick(0, 0, 0, 1);
      tick(0, 0, 0, 1);
      tick(0, 0, 0, 0);
      // R3: sync loads start line 10
      tag = "R3"; tick(0, 0, 1, 0); tick(0, 0, 0, 0);
      tag = "R4"; for (int i = 0; i < 5; i++) tick(0, 0, 0, 1);
      tick(0, 0, 0, 0);
      // R5: wrap from 63
      tag = "R5"; tick(1, 60, 0, 0); tick(0, 0, 1, 0);
      for (int i = 0; i < 6; i++) tick(0, 0, 0, 1);
      tick(0, 0, 0, 0);
      // R6: long duty, indicator in slot 64
      tag = "R6"; duty_long = 1'b1; plus_one_en = 1'b1;
      tick(1, 5, 0, 0); tick(0, 0, 1, 0);
      for (int i = 0; i < 64; i++) tick(0, 0, 0, 1);
      tick(0, 0, 0, 0);
      tag = "R10"; tick(0, 0, 0, 1); tick(0, 0, 0, 1); tick(0, 0, 0, 0);
      // R7: short duty, indicator in slot 32
      tag = "R7"; duty_long = 1'b0;
      tick(0, 0, 1, 0);
      for (int i = 0; i < 32; i++) tick(0, 0, 0, 1);
      tick(0, 0, 0, 0);
      tag = "R10"; tick(0, 0, 0, 1); tick(0, 0, 0, 0);
      // R8: mode off, no indicator in either duty
      tag = "R8"; plus_one_en = 1'b0;
      tick(0, 0, 1, 0);
      for (int i = 0; i < 70; i++) tick(0, 0, 0, 1);
      tick(0, 0, 0, 0);
      // R9: sync and line clock together
      tag = "R9"; plus_one_en = 1'b1;
      tick(1, 33, 0, 1); tick(0, 0, 1, 1); tick(0, 0, 0, 0);
      // random mix
      tag = "R10";
      for (int i = 0; i < 4000; i++) begin
         int r = $urandom_range(0, 99);
         if (i % 500 == 0) begin
            duty_long = 1'($urandom_range(0, 1));
            plus_one_en = 1'($urandom_range(0, 1));
         end
         tick(r < 4, $urandom_range(0, 63), r >= 96 || (r > 50 && r < 52), r >= 20);
      end
      tick(0, 0, 0, 0);
      @(negedge clk); check();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule